// File: doc/BRIEF.md
# Serial Transmit Register Slave on a Request/Response Channel Pair

This block is a single-beat bus slave sitting on a pair of channels: a request channel (A) that carries gets and puts from a master, and a response channel (D) that carries acknowledgements back. Both channels use a valid/ready handshake. One word address in the slave's space is a transmit register. A put to that address hands one byte to an external serial transmitter. Every accepted request, wherever it is addressed, is answered with exactly one acknowledgement.

The control path is a three-state one-hot machine that serves one request at a time. It accepts a request only while idle. For a transmit put, it waits for the transmitter to be free and pulses a byte strobe. It then presents the acknowledgement until the master takes it. Throughput is therefore at most one transaction every two cycles. The master may withdraw a request that has not been accepted without any effect on the slave.

Top module: `tlsx_slave`

## Requirements
- R1: While the synchronous active-low reset is applied, and in the first cycle after it is released, a_ready is 1, d_valid is 0 and tx_strobe is 0.
- R2: A request is taken only on a clock edge where a_valid and a_ready are both 1. a_ready is never 1 while d_valid is 1. A request that is raised and withdrawn while a_ready is low produces no strobe and no response.
- R3: A put (a_opcode 0 for full or 1 for partial) whose address matches the transmit register on all bits above the byte-lane bits causes exactly one one-cycle tx_strobe. The byte is taken from the byte lane of a_data selected by the low address bits, with lane 0 at bits 7:0. tx_strobe is never high while tx_busy is high, and the slave waits as long as tx_busy stays high.
- R4: The cycle after tx_strobe, d_valid is 1.
- R5: Any request that is not a put to the transmit register raises d_valid in the cycle after acceptance, with no strobe. Its D opcode is 0 (acknowledge without data) unless the request is a get.
- R6: A get (a_opcode 4), at any address, is answered with D opcode 1 (acknowledge with data), and d_data is zero.
- R7: Each response carries the accepted request's source and size fields unchanged.
- R8: While d_valid is 1 and d_ready is 0, d_valid, d_opcode, d_source and d_size are held stable. The response completes on the edge where d_valid and d_ready are both 1.
- R9: At most one request is outstanding. a_ready is low from acceptance until the response completes, and the control states follow only the paths idle to acknowledge to idle, and idle to transmit to acknowledge to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_valid | input | 1 | Request valid |
| a_ready | output | 1 | Slave can take a request |
| a_opcode | input | 3 | Request opcode: 0 put full, 1 put partial, 4 get |
| a_addr | input | AW (16) | Byte address |
| a_data | input | DW (32) | Write data |
| a_source | input | SW (4) | Requester tag |
| a_size | input | ZW (2) | Log2 of transfer size |
| d_valid | output | 1 | Response valid |
| d_ready | input | 1 | Master takes the response |
| d_opcode | output | 3 | 0 acknowledge, 1 acknowledge with data |
| d_data | output | DW (32) | Read data, always zero |
| d_source | output | SW (4) | Echoed requester tag |
| d_size | output | ZW (2) | Echoed size |
| tx_busy | input | 1 | Transmitter cannot take a byte |
| tx_strobe | output | 1 | One-cycle byte valid toward the transmitter |
| tx_byte | output | 8 | Byte to transmit |

## Verification
A corrupted control state shows at the ports within one cycle. It appears as a_ready and d_valid high together, as a response with no matching request, or as a stall where neither handshake side is ever ready. A wrong latched field shows on the next completed response or strobe as a mismatched opcode, source, size or byte. The bench keeps its own queue of expected responses and bytes, and compares each completion in order. Backpressure on the response channel and a randomly busy transmitter move the completion cycles, and the bench checks those cycles too.

// File: rtl/tlsx_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the transmit register slave.
// Assumes single-beat requests only.
package tlsx_pkg;
    // One-hot control states; values are visible to the checks below.
    typedef enum logic [2:0] {
        ST_IDLE = 3'b100,
        ST_TXO  = 3'b001,
        ST_ACK  = 3'b010
    } tlsx_state_e;

    localparam logic [2:0] A_PUT_FULL = 3'd0;
    localparam logic [2:0] A_PUT_PART = 3'd1;
    localparam logic [2:0] A_GET      = 3'd4;

    localparam logic [2:0] D_ACK      = 3'd0;
    localparam logic [2:0] D_ACK_DATA = 3'd1;
endpackage

// File: rtl/tlsx_decode.sv
`timescale 1ns/1ps
// Request decoder: classifies an A-channel request and picks the write byte lane.
// Purely combinational; assumes DW is a power-of-two multiple of 8.
module tlsx_decode
    import tlsx_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter logic [AW-1:0] TXO_ADDR = 16'h0010
) (
    input  logic [2:0]    opcode,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          go_txo,
    output logic [2:0]    rsp_op,
    output logic [7:0]    lane_byte
);
    localparam int LB = $clog2(DW / 8);

    logic is_put;
    logic hit;

    // Classify opcode and compare the word part of the address.
    always_comb begin
        is_put = (opcode == A_PUT_FULL) || (opcode == A_PUT_PART);
        hit    = (addr[AW-1:LB] == TXO_ADDR[AW-1:LB]);
        go_txo = is_put && hit;
        rsp_op = (opcode == A_GET) ? D_ACK_DATA : D_ACK;
    end

    // Byte lane selection depends on whether the bus is wider than a byte.
    generate
        if (LB > 0) begin : g_lanes
            always_comb lane_byte = wdata[int'(addr[LB-1:0]) * 8 +: 8];
        end else begin : g_single
            always_comb lane_byte = wdata[7:0];
        end
    endgenerate
endmodule

// File: rtl/tlsx_ctrl.sv
`timescale 1ns/1ps
// One-hot control for the slave: idle -> (transmit ->) acknowledge -> idle.
// Accepts only while idle; assumes tx_busy and d_ready are synchronous to clk.
module tlsx_ctrl
    import tlsx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_valid,
    input  logic go_txo,
    input  logic tx_busy,
    input  logic d_ready,
    output logic a_ready,
    output logic capture,
    output logic tx_strobe,
    output logic d_valid
);
    tlsx_state_e state_q, state_d;

    // Decode outputs straight from the current state.
    always_comb begin
        a_ready   = (state_q == ST_IDLE);
        capture   = a_ready && a_valid;
        tx_strobe = (state_q == ST_TXO) && !tx_busy;
        d_valid   = (state_q == ST_ACK);
    end

    // Next-state selection, each step gated by its handshake.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (a_valid) state_d = go_txo ? ST_TXO : ST_ACK;
            ST_TXO:  if (!tx_busy) state_d = ST_ACK;
            ST_ACK:  if (d_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_q) == 1);
    p_txo_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TXO) |=> (state_q inside {ST_TXO, ST_ACK}));
    p_ack_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK) |=> (state_q inside {ST_ACK, ST_IDLE}));
    p_ready_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        a_ready |-> !d_valid);
    p_strobe_then_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |=> d_valid);
    p_busy_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_TXO) && tx_busy) |=> !d_valid);
endmodule

// File: rtl/tlsx_resp.sv
`timescale 1ns/1ps
// Response and byte holding registers, loaded only on request acceptance.
// Assumes capture is high only while the control is idle.
module tlsx_resp #(
    parameter int SW = 4,
    parameter int ZW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [2:0]    op_in,
    input  logic [SW-1:0] src_in,
    input  logic [ZW-1:0] size_in,
    input  logic [7:0]    byte_in,
    input  logic          d_valid,
    input  logic          d_ready,
    output logic [2:0]    d_opcode,
    output logic [SW-1:0] d_source,
    output logic [ZW-1:0] d_size,
    output logic [7:0]    tx_byte
);
    // Latch the response fields and write byte at the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_opcode <= '0;
            d_source <= '0;
            d_size   <= '0;
            tx_byte  <= '0;
        end else if (capture) begin
            d_opcode <= op_in;
            d_source <= src_in;
            d_size   <= size_in;
            tx_byte  <= byte_in;
        end
    end

    p_hold_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_ready) |=> (d_valid && $stable(d_opcode)
                                   && $stable(d_source) && $stable(d_size)));
    p_no_capture_in_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |-> !capture);
endmodule

// File: rtl/tlsx_slave.sv
`timescale 1ns/1ps
// Transmit register slave: single-beat A/D channel slave whose put to the
// transmit address strobes one byte to a serial transmitter.
// Half bandwidth by design; assumes single-beat requests and a synchronous reset.
module tlsx_slave #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int SW = 4,
    parameter int ZW = 2,
    parameter logic [AW-1:0] TXO_ADDR = 16'h0010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_valid,
    output logic          a_ready,
    input  logic [2:0]    a_opcode,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_data,
    input  logic [SW-1:0] a_source,
    input  logic [ZW-1:0] a_size,
    output logic          d_valid,
    input  logic          d_ready,
    output logic [2:0]    d_opcode,
    output logic [DW-1:0] d_data,
    output logic [SW-1:0] d_source,
    output logic [ZW-1:0] d_size,
    input  logic          tx_busy,
    output logic          tx_strobe,
    output logic [7:0]    tx_byte
);
    logic       go_txo;
    logic       capture;
    logic [2:0] rsp_op;
    logic [7:0] lane_byte;

    tlsx_decode #(.AW(AW), .DW(DW), .TXO_ADDR(TXO_ADDR)) u_decode (
        .opcode    (a_opcode),
        .addr      (a_addr),
        .wdata     (a_data),
        .go_txo    (go_txo),
        .rsp_op    (rsp_op),
        .lane_byte (lane_byte)
    );

    tlsx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_valid   (a_valid),
        .go_txo    (go_txo),
        .tx_busy   (tx_busy),
        .d_ready   (d_ready),
        .a_ready   (a_ready),
        .capture   (capture),
        .tx_strobe (tx_strobe),
        .d_valid   (d_valid)
    );

    tlsx_resp #(.SW(SW), .ZW(ZW)) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .op_in    (rsp_op),
        .src_in   (a_source),
        .size_in  (a_size),
        .byte_in  (lane_byte),
        .d_valid  (d_valid),
        .d_ready  (d_ready),
        .d_opcode (d_opcode),
        .d_source (d_source),
        .d_size   (d_size),
        .tx_byte  (tx_byte)
    );

    // No readable registers: read data is always zero.
    always_comb d_data = '0;

    p_ack_completes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_ready) |=> a_ready);
endmodule

// File: tb/tb_tlsx_slave.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected responses and bytes,
// the negedge monitor pops and compares them as the slave produces them.
module tb_tlsx_slave;
    localparam int AW = 16, DW = 32, SW = 4, ZW = 2;
    localparam logic [AW-1:0] TXO = 16'h0010;

    logic clk = 0, rst_n = 0;
    logic a_valid = 0, a_ready;
    logic [2:0] a_opcode = 0;
    logic [AW-1:0] a_addr = 0;
    logic [DW-1:0] a_data = 0;
    logic [SW-1:0] a_source = 0;
    logic [ZW-1:0] a_size = 0;
    logic d_valid, d_ready = 1;
    logic [2:0] d_opcode;
    logic [DW-1:0] d_data;
    logic [SW-1:0] d_source;
    logic [ZW-1:0] d_size;
    logic tx_busy = 0, tx_strobe;
    logic [7:0] tx_byte;

    tlsx_slave #(.AW(AW), .DW(DW), .SW(SW), .ZW(ZW), .TXO_ADDR(TXO)) dut (.*);

    always #2.5 clk = ~clk;

    typedef struct { logic [2:0] op; logic [SW-1:0] src; logic [ZW-1:0] sz; } rsp_t;
    rsp_t exp_rsp[$];
    logic [7:0] exp_byte[$];
    int checks = 0, fails = 0;
    int dr_mode = 0, busy_mode = 0;
    bit done = 0, mon_on = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    function automatic bit is_txo(input logic [2:0] op, input logic [AW-1:0] ad);
        return (op == 3'd0 || op == 3'd1) && (ad[AW-1:2] == TXO[AW-1:2]);
    endfunction

    // Drive d_ready and tx_busy away from the edge according to the modes.
    always @(posedge clk) begin
        #1;
        d_ready = (dr_mode == 0) ? 1'b1 : (dr_mode == 1) ? 1'($urandom_range(0, 1)) : 1'b0;
        tx_busy = (busy_mode == 0) ? 1'b0 : (busy_mode == 1) ? 1'($urandom_range(0, 1)) : 1'b1;
    end

    // Driver: queue expectations, then hold the request until accepted.
    task automatic send(input logic [2:0] op, input logic [AW-1:0] ad,
                        input logic [DW-1:0] dat, input logic [SW-1:0] src, input logic [ZW-1:0] sz);
        rsp_t r;
        r.op = (op == 3'd4) ? 3'd1 : 3'd0;
        r.src = src;
        r.sz = sz;
        exp_rsp.push_back(r);
        if (is_txo(op, ad)) exp_byte.push_back(8'(dat >> (8 * ad[1:0])));
        @(posedge clk); #1;
        a_valid = 1; a_opcode = op; a_addr = ad; a_data = dat; a_source = src; a_size = sz;
        @(negedge clk);
        while (!a_ready) @(negedge clk);
        @(posedge clk); #1;
        a_valid = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && (exp_rsp.size() != 0 || exp_byte.size() != 0); i++)
            @(negedge clk);
    endtask

    // Monitor: timing checks relative to the previous cycle and in-order compares.
    bit acc_prev = 0, acc_txo_prev = 0, strobe_prev = 0, hold_prev = 0;
    logic [2:0] h_op; logic [SW-1:0] h_src; logic [ZW-1:0] h_sz;
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (acc_prev) begin
                chk(!a_ready, "R9 a_ready after accept", a_ready, 0);
                if (!acc_txo_prev) chk(d_valid, "R5 d_valid after accept", d_valid, 1);
            end
            if (strobe_prev) chk(d_valid, "R4 d_valid after strobe", d_valid, 1);
            if (hold_prev)
                chk(d_valid && d_opcode == h_op && d_source == h_src && d_size == h_sz,
                    "R8 held response", {d_valid, d_opcode, d_source, d_size}, {1'b1, h_op, h_src, h_sz});
            if (d_valid) chk(!a_ready, "R2 a_ready with d_valid", a_ready, 0);
            if (tx_strobe) begin
                chk(!tx_busy, "R3 strobe while busy", tx_busy, 0);
                if (exp_byte.size() == 0) chk(0, "R2 unexpected strobe", tx_byte, 0);
                else begin
                    logic [7:0] eb;
                    eb = exp_byte.pop_front();
                    chk(tx_byte == eb, "R3 byte", tx_byte, eb);
                end
            end
            if (d_valid && d_ready) begin
                if (exp_rsp.size() == 0) chk(0, "R2 unexpected response", d_opcode, 0);
                else begin
                    rsp_t e;
                    e = exp_rsp.pop_front();
                    chk(d_opcode == e.op, "R5 R6 opcode", d_opcode, e.op);
                    chk(d_data == '0, "R6 data zero", d_data, 0);
                    chk(d_source == e.src && d_size == e.sz, "R7 echo", {d_source, d_size}, {e.src, e.sz});
                end
            end
        end
        acc_prev = a_valid && a_ready;
        acc_txo_prev = is_txo(a_opcode, a_addr);
        strobe_prev = tx_strobe;
        hold_prev = d_valid && !d_ready;
        h_op = d_opcode; h_src = d_source; h_sz = d_size;
    end

    initial begin
        #(5.0 * 150000);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(a_ready && !d_valid && !tx_strobe, "R1 in reset", {a_ready, d_valid, tx_strobe}, 3'b100);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk(a_ready && !d_valid && !tx_strobe, "R1 after reset", {a_ready, d_valid, tx_strobe}, 3'b100);
        mon_on = 1;

        // Directed patterns: every lane, other address, gets, other opcode.
        send(3'd0, TXO, 32'h000000A5, 4'h1, 2'd0);
        send(3'd1, TXO + 1, 32'h0000C300, 4'h2, 2'd0);
        send(3'd1, TXO + 2, 32'h00770000, 4'h3, 2'd0);
        send(3'd1, TXO + 3, 32'h9E000000, 4'h4, 2'd0);
        send(3'd0, 16'h0020, 32'hFFFFFFFF, 4'h5, 2'd2);
        send(3'd4, TXO, 32'h0, 4'h6, 2'd2);
        send(3'd4, 16'h0044, 32'h0, 4'h7, 2'd1);
        send(3'd2, TXO, 32'h11, 4'h8, 2'd0);
        drain();

        // Random traffic with response backpressure and a busy transmitter.
        dr_mode = 1; busy_mode = 1;
        for (int i = 0; i < 60; i++) begin
            logic [2:0] op;
            logic [AW-1:0] ad;
            case ($urandom_range(0, 3))
                0: op = 3'd0; 1: op = 3'd1; 2: op = 3'd4; default: op = 3'd2;
            endcase
            ad = $urandom_range(0, 1) ? (TXO + 16'($urandom_range(0, 3))) : 16'($urandom_range(32, 255));
            send(op, ad, $urandom, 4'($urandom), 2'($urandom));
        end
        drain();

        // Withdrawn request while a response is stalled: no effect (R2), hold (R8).
        dr_mode = 2; busy_mode = 0;
        send(3'd0, 16'h0030, 32'h0, 4'hA, 2'd1);
        @(posedge clk); #1;
        a_valid = 1; a_opcode = 3'd0; a_addr = TXO; a_data = 32'h5A; a_source = 4'hB;
        repeat (4) @(posedge clk);
        #1 a_valid = 0;
        repeat (3) @(posedge clk);
        dr_mode = 0;
        drain();
        repeat (5) @(negedge clk);
        chk(exp_rsp.size() == 0 && !d_valid, "R2 withdrawn request ignored", exp_rsp.size(), 0);

        // Transmitter held busy: slave waits with no strobe and no response (R3).
        busy_mode = 2;
        send(3'd0, TXO, 32'h3C, 4'hC, 2'd0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!d_valid && !tx_strobe && !a_ready, "R3 wait on busy", {d_valid, tx_strobe, a_ready}, 0);
        end
        busy_mode = 0;
        drain();
        repeat (3) @(negedge clk);
        chk(exp_rsp.size() == 0 && exp_byte.size() == 0, "R9 all completions seen",
            exp_rsp.size() + exp_byte.size(), 0);
        chk(a_ready && !d_valid, "R9 idle at end", {a_ready, d_valid}, 2'b10);
        finish_run();
    end
endmodule